// File: doc/BRIEF.md
# Leveled Interrupt Pending and Priority Unit

This block keeps track of pending interrupt sources arranged into priority levels. Each level owns a 64-bit source vector, and a 32-bit level summary register has one bit per level. Post and clear commands each name a level and a source index. A level's summary bit stays set until every source in that level has been cleared. A single clear-all command empties all of the state at once.

A combinational evaluator takes the software request word and the summary register and produces a winning priority and a mask of the contributing levels. Software levels 1 to 15 map to priorities 1 to 15. External levels 16 to 31 map to their own numbers, and any external level beats any software level. When the evaluate strobe is high and the winning priority is above the current processor priority, the block raises a taken pulse and latches the priority and the mask. A later commit pulse moves the latched pair into the summary and ID output registers. A separate registered output tells whether anything is pending at a word-aligned program counter.

Top module: `lvl_irq_unit`

## Requirements
- R1: After reset, the summary register, the ID and summary outputs, the pending output, the taken pulse and the error pulse are all zero.
- R2: A post with level below 32 and index below 64 sets bit index of that level's vector and sets bit level of `lvl_sum_o`, visible one cycle after the command.
- R3: A clear with valid level and index clears that vector bit. The level's bit in `lvl_sum_o` falls only when the whole vector becomes zero.
- R4: A clear-all zeroes every vector and `lvl_sum_o` in one cycle. It takes precedence over a post or clear in the same cycle.
- R5: If a post and a clear name the same bit in the same cycle, the bit ends up set.
- R6: A post or clear with level of 32 or more, or index of 64 or more, changes no state and produces a one-cycle `err_o` pulse on the next cycle.
- R7: `pend_o` is 1 one cycle later exactly when `lvl_sum_o` is nonzero and `pc_i[1:0]` is 00.
- R8: For each software request bit i in 1..15, the candidate priority is i and bit i enters the mask. Bit 0 and bits 16..31 of `sw_req_i` are ignored.
- R9: For each set summary bit i in 16..31, bit i enters the mask and the priority becomes i. The highest such level overrides every software result. Summary bits 0..15 take no part.
- R10: An `eval_i` cycle whose priority is nonzero and strictly greater than `cur_ipl_i` gives a `take_o` pulse one cycle later and latches the priority and the mask. Otherwise nothing is latched and no pulse is given.
- R11: A commit while latched info is held copies the mask to `isr_o` and the priority to `intid_o` on the next cycle and drops the held flag.
- R12: A commit with no held info leaves `isr_o` and `intid_o` unchanged and gives a one-cycle `err_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_v_i | input | 1 | Post command valid |
| post_lvl_i | input | 6 | Post level |
| post_idx_i | input | 7 | Post source index |
| clr_v_i | input | 1 | Clear command valid |
| clr_lvl_i | input | 6 | Clear level |
| clr_idx_i | input | 7 | Clear source index |
| clr_all_i | input | 1 | Clear every level |
| sw_req_i | input | 32 | Software interrupt request word |
| cur_ipl_i | input | 5 | Current processor priority level |
| pc_i | input | 32 | Program counter for the pending check |
| eval_i | input | 1 | Evaluate-and-latch strobe |
| commit_i | input | 1 | Commit latched info to outputs |
| lvl_sum_o | output | 32 | Level summary register |
| pend_o | output | 1 | Pending at aligned PC |
| take_o | output | 1 | Interrupt taken pulse |
| isr_o | output | 32 | Committed summary mask |
| intid_o | output | 5 | Committed interrupt priority |
| err_o | output | 1 | Bad command or empty commit pulse |

## Verification
Every result is registered once. `lvl_sum_o`, `take_o` and `err_o` change at the first edge after the command. `pend_o` is computed from the summary as it stands at that edge, so a post is seen on `pend_o` two edges after it. `isr_o` and `intid_o` move at the edge that follows the commit. The bench drives inputs on the falling edge, lets one or two rising edges pass depending on the result, and samples on the falling edge that follows. Expected values come from a bench model of the vectors and from a priority function written directly from R8 and R9.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned NUM_LEVELS = 32;
  localparam int unsigned SRC_W      = 64;
  localparam int unsigned SW_LO      = 1;
  localparam int unsigned SW_HI      = 16;
  localparam int unsigned EXT_LO     = 16;
  localparam int unsigned EXT_HI     = 32;
  localparam int unsigned PRIO_W     = $clog2(NUM_LEVELS);
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS) + 1;
  localparam int unsigned IDX_W      = $clog2(SRC_W) + 1;

  typedef struct packed {
    logic [PRIO_W-1:0]     prio;
    logic [NUM_LEVELS-1:0] mask;
  } irq_info_t;
endpackage

// File: rtl/lvl_irq_store.sv
module lvl_irq_store
  import lvl_irq_pkg::*;
#(
  parameter int unsigned LEVELS = NUM_LEVELS,
  parameter int unsigned WIDTH  = SRC_W,
  parameter int unsigned LW     = LVL_W,
  parameter int unsigned IW     = IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_v,
  input  logic [LW-1:0]     post_lvl,
  input  logic [IW-1:0]     post_idx,
  input  logic              clr_v,
  input  logic [LW-1:0]     clr_lvl,
  input  logic [IW-1:0]     clr_idx,
  input  logic              clr_all,
  output logic [LEVELS-1:0] summary,
  output logic              cmd_err
);
  localparam int unsigned SW = $clog2(WIDTH);

  logic post_ok, clr_ok;
  assign post_ok = post_v && (post_lvl < LW'(LEVELS)) && (post_idx < IW'(WIDTH));
  assign clr_ok  = clr_v  && (clr_lvl  < LW'(LEVELS)) && (clr_idx  < IW'(WIDTH));

  logic [WIDTH-1:0] set_bit, clr_bit;
  assign set_bit = WIDTH'(1) << post_idx[SW-1:0];
  assign clr_bit = WIDTH'(1) << clr_idx[SW-1:0];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic             post_here, clr_here, sum_q;
    logic [WIDTH-1:0] vec_q, vec_nxt;
    assign post_here = post_ok && (post_lvl == LW'(l));
    assign clr_here  = clr_ok  && (clr_lvl  == LW'(l));
    assign vec_nxt = (vec_q & ~(clr_here ? clr_bit : '0)) | (post_here ? set_bit : '0);
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        vec_q <= '0;
        sum_q <= 1'b0;
      end else begin
        vec_q <= vec_nxt;
        if (post_here)     sum_q <= 1'b1;
        else if (clr_here) sum_q <= |vec_nxt;
      end
    end
    assign summary[l] = sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= (post_v && !post_ok) || (clr_v && !clr_ok);
  end

  // R4
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (summary == '0));
  // R2
  post_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> summary[$past(post_lvl[LW-2:0])]);
  // R6
  bad_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
    (post_v && !post_ok) |=> cmd_err);
endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio
  import lvl_irq_pkg::*;
(
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [NUM_LEVELS-1:0] summary,
  input  logic [PRIO_W-1:0]     cur_ipl,
  output irq_info_t             info,
  output logic                  above
);
  always_comb begin
    info.prio = '0;
    info.mask = '0;
    for (int i = SW_LO; i < SW_HI; i++) begin
      if (sw_req[i]) begin
        info.prio    = PRIO_W'(i - SW_LO + 1);
        info.mask[i] = 1'b1;
      end
    end
    for (int i = EXT_LO; i < EXT_HI; i++) begin
      if (summary[i]) begin
        info.prio    = PRIO_W'(i);
        info.mask[i] = 1'b1;
      end
    end
    above = (info.prio != '0) && (info.prio > cur_ipl);
  end

  // R8
  prio_mask_chk: assert final ((info.prio == '0) == (info.mask == '0));
endmodule

// File: rtl/lvl_irq_latch.sv
module lvl_irq_latch
  import lvl_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  eval,
  input  logic                  above,
  input  irq_info_t             cand,
  input  logic                  commit,
  output logic                  take,
  output logic [NUM_LEVELS-1:0] isr,
  output logic [PRIO_W-1:0]     intid,
  output logic                  commit_err
);
  irq_info_t held_q;
  logic      held_v;
  logic      grab;
  assign grab = eval && above;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= '0;
      held_v     <= 1'b0;
      take       <= 1'b0;
      isr        <= '0;
      intid      <= '0;
      commit_err <= 1'b0;
    end else begin
      take       <= grab;
      commit_err <= commit && !held_v;
      if (commit && held_v) begin
        isr   <= held_q.mask;
        intid <= held_q.prio;
      end
      if (grab) begin
        held_q <= cand;
        held_v <= 1'b1;
      end else if (commit) begin
        held_v <= 1'b0;
      end
    end
  end

  // R12
  empty_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !held_v) |=> ($stable(isr) && $stable(intid) && commit_err));
  // R11
  commit_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && held_v && !grab) |=> !held_v);
  // R10
  take_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (held_v && held_q.prio != '0));
endmodule

// File: rtl/lvl_irq_unit.sv
module lvl_irq_unit
  import lvl_irq_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_v_i,
  input  logic [LVL_W-1:0]      post_lvl_i,
  input  logic [IDX_W-1:0]      post_idx_i,
  input  logic                  clr_v_i,
  input  logic [LVL_W-1:0]      clr_lvl_i,
  input  logic [IDX_W-1:0]      clr_idx_i,
  input  logic                  clr_all_i,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  input  logic [PRIO_W-1:0]     cur_ipl_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic                  eval_i,
  input  logic                  commit_i,
  output logic [NUM_LEVELS-1:0] lvl_sum_o,
  output logic                  pend_o,
  output logic                  take_o,
  output logic [NUM_LEVELS-1:0] isr_o,
  output logic [PRIO_W-1:0]     intid_o,
  output logic                  err_o
);
  logic      cmd_err, commit_err, above;
  irq_info_t cand;

  lvl_irq_store u_store (
    .clk(clk), .rst(rst),
    .post_v(post_v_i), .post_lvl(post_lvl_i), .post_idx(post_idx_i),
    .clr_v(clr_v_i), .clr_lvl(clr_lvl_i), .clr_idx(clr_idx_i),
    .clr_all(clr_all_i), .summary(lvl_sum_o), .cmd_err(cmd_err)
  );

  lvl_irq_prio u_prio (
    .sw_req(sw_req_i), .summary(lvl_sum_o), .cur_ipl(cur_ipl_i),
    .info(cand), .above(above)
  );

  lvl_irq_latch u_latch (
    .clk(clk), .rst(rst), .eval(eval_i), .above(above), .cand(cand),
    .commit(commit_i), .take(take_o), .isr(isr_o), .intid(intid_o),
    .commit_err(commit_err)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_o <= 1'b0;
    else     pend_o <= (lvl_sum_o != '0) && (pc_i[1:0] == 2'b00);
  end

  assign err_o = cmd_err || commit_err;

  // R7
  pend_needs_state_chk: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> ($past(lvl_sum_o) != '0));
endmodule

// File: tb/lvl_irq_unit_bench.sv
module lvl_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic post_v = 0, clr_v = 0, clr_all = 0, eval = 0, commit = 0;
  logic [5:0] post_lvl = 0, clr_lvl = 0;
  logic [6:0] post_idx = 0, clr_idx = 0;
  logic [31:0] sw_req = 0, pc = 0;
  logic [4:0] cur_ipl = 0;
  logic [31:0] lvl_sum, isr;
  logic pend, take, err;
  logic [4:0] intid;
  int checks = 0, fails = 0;
  logic [63:0] mvec [32];
  logic [31:0] msum;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_unit u_lvl_irq_unit (
    .clk(clk), .rst(rst), .post_v_i(post_v), .post_lvl_i(post_lvl), .post_idx_i(post_idx),
    .clr_v_i(clr_v), .clr_lvl_i(clr_lvl), .clr_idx_i(clr_idx), .clr_all_i(clr_all),
    .sw_req_i(sw_req), .cur_ipl_i(cur_ipl), .pc_i(pc), .eval_i(eval), .commit_i(commit),
    .lvl_sum_o(lvl_sum), .pend_o(pend), .take_o(take), .isr_o(isr), .intid_o(intid), .err_o(err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    post_v = 0; clr_v = 0; clr_all = 0; eval = 0; commit = 0;
  endtask

  task automatic do_post(int l, int i);
    post_v = 1; post_lvl = 6'(l); post_idx = 7'(i); step(); idle();
    mvec[l][i] = 1'b1; msum[l] = 1'b1;
  endtask

  task automatic do_clr(int l, int i);
    clr_v = 1; clr_lvl = 6'(l); clr_idx = 7'(i); step(); idle();
    mvec[l][i] = 1'b0; msum[l] = (mvec[l] != 0);
  endtask

  function automatic logic [36:0] model_eval(logic [31:0] sw, logic [31:0] sm);
    logic [4:0] p = 0; logic [31:0] m = 0;
    for (int i = 1; i < 16; i++) if (sw[i]) begin p = 5'(i); m[i] = 1; end
    for (int i = 16; i < 32; i++) if (sm[i]) begin p = 5'(i); m[i] = 1; end
    return {p, m};
  endfunction

  task automatic try_take(string req, logic [31:0] sw, logic [4:0] ipl);
    logic [36:0] e = model_eval(sw, msum);
    logic exp_take = (e[36:32] != 0) && (e[36:32] > ipl);
    logic [31:0] old_isr = isr; logic [4:0] old_id = intid;
    sw_req = sw; cur_ipl = ipl; eval = 1; step(); idle();
    chk({req, " take"}, 64'(take), 64'(exp_take));
    commit = 1; step(); idle();
    chk({req, " isr"}, 64'(isr), exp_take ? 64'(e[31:0]) : 64'(old_isr));
    chk({req, " intid"}, 64'(intid), exp_take ? 64'(e[36:32]) : 64'(old_id));
    chk({req, " err"}, 64'(err), 64'(!exp_take));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < 32; l++) mvec[l] = 0;
    msum = 0;
    repeat (3) @(negedge clk);
    rst = 0; @(negedge clk);
    // R1
    chk("R1 sum", 64'(lvl_sum), 0); chk("R1 isr", 64'(isr), 0);
    chk("R1 id", 64'(intid), 0); chk("R1 pend", 64'(pend), 0);
    chk("R1 take", 64'(take), 0); chk("R1 err", 64'(err), 0);
    // R2 sweep over every level
    for (int l = 0; l < 32; l++) begin
      do_post(l, (l * 7) % 64);
      chk("R2 post", 64'(lvl_sum), 64'(msum));
    end
    // R4 clear-all with a simultaneous post
    clr_all = 1; post_v = 1; post_lvl = 3; post_idx = 1; step(); idle();
    for (int l = 0; l < 32; l++) mvec[l] = 0;
    msum = 0;
    chk("R4 clear all", 64'(lvl_sum), 0);
    // R3 two sources in one level
    for (int l = 0; l < 32; l += 5) begin
      do_post(l, 0); do_post(l, 63);
      do_clr(l, 0);
      chk("R3 partial", 64'(lvl_sum), 64'(msum));
      do_clr(l, 63);
      chk("R3 empty", 64'(lvl_sum), 64'(msum));
    end
    // R5 post and clear on the same bit
    post_v = 1; post_lvl = 9; post_idx = 40; clr_v = 1; clr_lvl = 9; clr_idx = 40;
    step(); idle(); mvec[9][40] = 1; msum[9] = 1;
    chk("R5 post wins", 64'(lvl_sum), 64'(msum));
    do_clr(9, 40);
    chk("R5 bit was set", 64'(lvl_sum), 64'(msum));
    // R6 out-of-range commands
    post_v = 1; post_lvl = 32; post_idx = 0; step(); idle();
    chk("R6 lvl err", 64'(err), 1); chk("R6 lvl state", 64'(lvl_sum), 64'(msum));
    post_v = 1; post_lvl = 4; post_idx = 64; step(); idle();
    chk("R6 idx err", 64'(err), 1); chk("R6 idx state", 64'(lvl_sum), 64'(msum));
    clr_v = 1; clr_lvl = 40; clr_idx = 3; step();
    chk("R6 clr err", 64'(err), 1); idle(); step();
    chk("R6 err one cycle", 64'(err), 0);
    // R7 pending output over pc low bits
    do_post(2, 5);
    for (int p = 0; p < 4; p++) begin
      pc = 32'h100 | 32'(p); step(); step();
      chk("R7 pend", 64'(pend), 64'(p == 0));
    end
    do_clr(2, 5); pc = 0; step(); step();
    chk("R7 pend empty", 64'(pend), 0);
    // R12 commit with nothing held
    commit = 1; step(); idle();
    chk("R12 err", 64'(err), 1); chk("R12 isr", 64'(isr), 0); chk("R12 id", 64'(intid), 0);
    // R8 software sweep, including ignored bits 0 and 16..31
    for (int i = 0; i < 32; i++) try_take("R8 sw", 32'(1) << i, 0);
    try_take("R8 sw multi", 32'h0000_0F06, 0);
    // R9 external sweep with all software bits set
    for (int l = 0; l < 32; l++) begin
      do_post(l, 11);
      try_take("R9 ext", 32'hFFFF_FFFF, 0);
      do_clr(l, 11);
    end
    // R10 ipl boundary
    do_post(20, 2);
    try_take("R10 equal", 0, 20);
    try_take("R10 below", 0, 19);
    try_take("R10 sw over ipl", 32'h0000_0100, 8);
    do_clr(20, 2);
    try_take("R10 sw equal", 32'h0000_0100, 8);
    // R11 held flag drops after commit
    sw_req = 32'h8; cur_ipl = 0; eval = 1; step(); idle();
    commit = 1; step(); idle();
    chk("R11 id", 64'(intid), 3);
    commit = 1; step(); idle();
    chk("R11 second commit err", 64'(err), 1); chk("R11 id kept", 64'(intid), 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule